// File: doc/BRIEF.md
# Edge-Triggered Memory-to-Peripheral Transfer Channel

This block is one transfer channel that copies words out of a memory buffer into a peripheral's data register, one word per rising edge of a request line from that peripheral. A block transfer is organized as a number of frames, and each frame holds a fixed number of elements. Software programs the source address, the element and frame counts and a frame stride, and then pulses the enable input. The channel fetches a word from memory on every rising edge of the request line. In the following cycle it hands the word to the peripheral.

When the last element of the last frame has been written, the channel clears its own enable bit. It also raises a one-cycle interrupt pulse and sets a sticky completion flag, which stays set until software clears it. Because the request is edge-triggered, a request level that is already high when software re-enables the channel starts nothing. The peripheral has to drop its request line and raise it again before a transfer begins. The interrupt marks the moment the final word reaches the peripheral's register, not the moment the peripheral has finished shifting it out. The peripheral therefore must not be shut down when the interrupt arrives.

Top module: `evdma_chan`

## Requirements
- R1: A rising edge of `sync_evt` seen while the channel is enabled and idle asserts `mem_rd` for that one cycle, with `mem_addr` set to the current source address. In the next cycle `per_wr` is high and `per_wdata` equals `mem_rdata`. `mem_rdata` is the memory's reply, returned one clock after the read.
- R2: Holding `sync_evt` high for any number of cycles causes exactly one transfer. A further transfer needs the line to go low and then high again.
- R3: Rising edges of `sync_evt` while `en_stat` is 0 cause no transfer and are not remembered. Enabling the channel while `sync_evt` is already high starts no transfer.
- R4: The first element is read from `cfg_src_addr`. After an element that is not the last one of its frame, the address increases by 1. After the last element of a frame, `cfg_frame_idx` is added instead, taken as a two's-complement value and wrapping at the address width.
- R5: A block holds (`cfg_elem_m1`+1) × (`cfg_frame_m1`+1) elements, so each count field encodes its count minus one.
- R6: `irq_pulse` is high for exactly one cycle, namely the cycle after the `per_wr` of the block's last element. In that same cycle `en_stat` has already returned to 0, and later edges move nothing.
- R7: `irq_flag` rises together with `irq_pulse` and stays at 1 until a cycle with `flag_clr` high. If completion and `flag_clr` occur in the same cycle, the flag is set.
- R8: A pulse on `en_set` while `en_stat` is 0 latches the address, stride and counts and sets `en_stat` in the next cycle. A new block therefore always restarts from `cfg_src_addr`.
- R9: After reset, `en_stat`, `irq_pulse`, `irq_flag`, `mem_rd` and `per_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_addr | input | ADDR_W | Start address of the buffer |
| cfg_elem_m1 | input | CNT_W | Elements per frame minus one |
| cfg_frame_m1 | input | CNT_W | Frames per block minus one |
| cfg_frame_idx | input | ADDR_W | Two's-complement stride added after a frame's last element |
| en_set | input | 1 | Software pulse that arms the channel |
| flag_clr | input | 1 | Software pulse that clears the completion flag |
| sync_evt | input | 1 | Transfer request from the peripheral |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data, one cycle after `mem_rd` |
| per_wr | output | 1 | Peripheral data-register write strobe |
| per_wdata | output | DATA_W | Word written to the peripheral |
| en_stat | output | 1 | Enable bit as seen by software |
| irq_pulse | output | 1 | One-cycle block-complete interrupt |
| irq_flag | output | 1 | Sticky block-complete flag |

## Verification
Faults in the address generator or the frame counters become visible at the ports when the next word written to the peripheral is wrong. At a frame boundary this happens within two cycles of the request edge that crosses it. A wrong element or frame count shows up as a block that ends early or late: the completion pulse and the cleared enable appear after the wrong number of writes. A fault in the registered copy of the request line shows up as an extra write or a missing one. This is seen on the first long-held request, or on the first enable issued while the request line is already high.

// File: rtl/evdma_pkg.sv
package evdma_pkg;
    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_MOVE = 1'b1
    } ev_state_e;
endpackage

// File: rtl/evdma_edge.sv
module evdma_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_in,
    input  logic arm,
    output logic fire
);
    logic lvl_d, lvl_q;

    // The registered copy follows the line in every cycle, so an enable
    // issued while the line is high sees no edge.
    always_comb begin
        lvl_d = ev_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign fire = arm & ev_in & ~lvl_q;

    p_one_fire_per_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/evdma_cnt.sv
module evdma_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] elem_m1,
    input  logic [CNT_W-1:0] frame_m1,
    output logic             frame_end,
    output logic             block_end
);
    typedef struct packed {
        logic [CNT_W-1:0] rl;
        logic [CNT_W-1:0] elem;
        logic [CNT_W-1:0] frame;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    assign frame_end = (cnt_q.elem == '0);
    assign block_end = frame_end && (cnt_q.frame == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.rl    = elem_m1;
            cnt_d.elem  = elem_m1;
            cnt_d.frame = frame_m1;
        end else if (step && !block_end) begin
            if (frame_end) begin
                cnt_d.elem  = cnt_q.rl;
                cnt_d.frame = cnt_q.frame - 1'b1;
            end else begin
                cnt_d.elem  = cnt_q.elem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_elem_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.elem <= cnt_q.rl);
endmodule

// File: rtl/evdma_agen.sv
module evdma_agen #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] idx,
    input  logic              step,
    input  logic              frame_end,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] idx;
    } ag_s;

    ag_s ag_d, ag_q;

    always_comb begin
        ag_d = ag_q;
        if (load) begin
            ag_d.addr = src;
            ag_d.idx  = idx;
        end else if (step) begin
            ag_d.addr = frame_end ? ag_q.addr + ag_q.idx
                                  : ag_q.addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ag_q <= '0;
        else        ag_q <= ag_d;
    end

    assign addr = ag_q.addr;

    p_addr_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !frame_end) |=> (addr == $past(addr) + ADDR_W'(1)));
endmodule

// File: rtl/evdma_chan.sv
module evdma_chan #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [CNT_W-1:0]  cfg_elem_m1,
    input  logic [CNT_W-1:0]  cfg_frame_m1,
    input  logic [ADDR_W-1:0] cfg_frame_idx,
    input  logic              en_set,
    input  logic              flag_clr,
    input  logic              sync_evt,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              per_wr,
    output logic [DATA_W-1:0] per_wdata,
    output logic              en_stat,
    output logic              irq_pulse,
    output logic              irq_flag
);
    import evdma_pkg::*;

    typedef struct packed {
        ev_state_e st;
        logic      en;
        logic      irq;
        logic      flag;
    } ctl_s;

    ctl_s ctl_d, ctl_q;
    logic fire, load, step, frame_end, block_end, done;

    assign load = en_set & ~ctl_q.en;
    assign step = (ctl_q.st == ST_MOVE);
    assign done = step & block_end;

    evdma_edge i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_in (sync_evt),
        .arm   (ctl_q.en & (ctl_q.st == ST_WAIT)),
        .fire  (fire)
    );

    evdma_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .elem_m1   (cfg_elem_m1),
        .frame_m1  (cfg_frame_m1),
        .frame_end (frame_end),
        .block_end (block_end)
    );

    evdma_agen #(.ADDR_W(ADDR_W)) i_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .src       (cfg_src_addr),
        .idx       (cfg_frame_idx),
        .step      (step),
        .frame_end (frame_end),
        .addr      (mem_addr)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.irq = done;
        case (ctl_q.st)
            ST_WAIT: if (fire) ctl_d.st = ST_MOVE;
            default: ctl_d.st = ST_WAIT;
        endcase
        if (load)      ctl_d.en = 1'b1;
        else if (done) ctl_d.en = 1'b0;
        ctl_d.flag = done | (ctl_q.flag & ~flag_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_WAIT, en: 1'b0, irq: 1'b0, flag: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign mem_rd    = fire;
    assign per_wr    = step;
    assign per_wdata = mem_rdata;
    assign en_stat   = ctl_q.en;
    assign irq_pulse = ctl_q.irq;
    assign irq_flag  = ctl_q.flag;

    p_wr_after_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> per_wr);
    p_no_rd_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_stat |-> !mem_rd);
    p_irq_drops_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !en_stat);
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);
endmodule

// File: tb/test_evdma_chan.sv
module test_evdma_chan;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 8;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [CW-1:0] e;
        logic [CW-1:0] f;
        logic [AW-1:0] idx;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{16'h0010, 8'd3, 8'd0, 16'h0000},
        '{16'h0100, 8'd2, 8'd2, 16'h0005},
        '{16'h0200, 8'd1, 8'd3, 16'hFFFD},
        '{16'h0300, 8'd0, 8'd4, 16'h0010}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] cfg_src_addr = '0, cfg_frame_idx = '0;
    logic [CW-1:0] cfg_elem_m1 = '0, cfg_frame_m1 = '0;
    logic en_set = 1'b0, flag_clr = 1'b0, sync_evt = 1'b0;
    logic mem_rd, per_wr, en_stat, irq_pulse, irq_flag;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0, per_wdata;

    int n_tests = 0, n_fail = 0;
    int wr_idx = 0, exp_total = 0, irq_cnt = 0;
    logic [AW-1:0] exp_addr [64];
    logic want_irq = 1'b0;

    always #10 clk = ~clk;

    evdma_chan #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_evdma_chan (
        .clk(clk), .rst_n(rst_n), .cfg_src_addr(cfg_src_addr),
        .cfg_elem_m1(cfg_elem_m1), .cfg_frame_m1(cfg_frame_m1),
        .cfg_frame_idx(cfg_frame_idx), .en_set(en_set), .flag_clr(flag_clr),
        .sync_evt(sync_evt), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .per_wr(per_wr), .per_wdata(per_wdata),
        .en_stat(en_stat), .irq_pulse(irq_pulse), .irq_flag(irq_flag)
    );

    function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
        return a * 16'd7 + 16'h1234;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mem_fn(mem_addr);

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Monitor: every peripheral write must carry the expected word (R1, R4).
    always @(negedge clk) begin
        if (rst_n) begin
            if (want_irq) begin
                chk(irq_pulse && !en_stat, "R6 irq timing", {irq_pulse, en_stat}, 2'b10);
                want_irq = 1'b0;
            end
            if (irq_pulse) irq_cnt++;
            if (per_wr) begin
                if (wr_idx < exp_total)
                    chk(per_wdata == mem_fn(exp_addr[wr_idx]), "R1/R4 write data",
                        per_wdata, mem_fn(exp_addr[wr_idx]));
                if (wr_idx == exp_total - 1) want_irq = 1'b1;
                wr_idx++;
            end
        end
    end

    task automatic edge_once();
        @(negedge clk) sync_evt = 1'b1;
        @(negedge clk) sync_evt = 1'b0;
        @(negedge clk);
    endtask

    task automatic setup(input vec_t v);
        logic [AW-1:0] a;
        cfg_src_addr = v.src; cfg_elem_m1 = v.e;
        cfg_frame_m1 = v.f;   cfg_frame_idx = v.idx;
        a = v.src; exp_total = 0;
        for (int fr = 0; fr <= int'(v.f); fr++)
            for (int el = 0; el <= int'(v.e); el++) begin
                exp_addr[exp_total] = a;
                exp_total++;
                a = (el == int'(v.e)) ? a + v.idx : a + 16'd1;
            end
        wr_idx = 0; irq_cnt = 0;
    endtask

    task automatic arm();
        @(negedge clk) en_set = 1'b1;
        @(negedge clk) en_set = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R9: reset state
        chk({en_stat, irq_pulse, irq_flag, mem_rd, per_wr} == 5'b0, "R9 reset",
            {en_stat, irq_pulse, irq_flag, mem_rd, per_wr}, 0);
        rst_n = 1'b1;

        // Vector table: full blocks (R4, R5, R6, R7, R8)
        for (int k = 0; k < 4; k++) begin
            setup(VECS[k]);
            arm();
            chk(en_stat == 1'b1, "R8 enable set", en_stat, 1);
            for (int n = 0; n < exp_total; n++) edge_once();
            @(negedge clk);
            chk(wr_idx == exp_total, "R5 block length", wr_idx, exp_total);
            chk(irq_cnt == 1, "R6 one pulse", irq_cnt, 1);
            chk(en_stat == 1'b0 && irq_flag == 1'b1, "R7 flag set, R6 en clear",
                {en_stat, irq_flag}, 2'b01);
            edge_once();
            chk(wr_idx == exp_total, "R6 no transfer after block", wr_idx, exp_total);
            chk(irq_flag == 1'b1, "R7 flag held", irq_flag, 1);
            @(negedge clk) flag_clr = 1'b1;
            @(negedge clk) flag_clr = 1'b0;
            chk(irq_flag == 1'b0, "R7 flag cleared", irq_flag, 0);
        end

        // R2: held level gives exactly one transfer
        setup(VECS[0]);
        arm();
        @(negedge clk) sync_evt = 1'b1;
        repeat (8) @(negedge clk);
        chk(wr_idx == 1, "R2 held level", wr_idx, 1);
        sync_evt = 1'b0;
        edge_once();
        chk(wr_idx == 2, "R2 next edge after low", wr_idx, 2);
        for (int n = 0; n < 2; n++) edge_once();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;

        // R3: edges while disabled and enable with the line high
        setup(VECS[1]);
        for (int n = 0; n < 3; n++) edge_once();
        chk(wr_idx == 0, "R3 disabled edges ignored", wr_idx, 0);
        @(negedge clk) sync_evt = 1'b1;
        arm();
        repeat (5) @(negedge clk);
        chk(wr_idx == 0 && en_stat == 1'b1, "R3 enable while high", wr_idx, 0);
        sync_evt = 1'b0;
        edge_once();
        chk(wr_idx == 1, "R3 first edge after low", wr_idx, 1);

        // R7: clear and completion in the same cycle, set wins; R8 reload
        flag_clr = 1'b1;
        for (int n = 1; n < exp_total; n++) edge_once();
        chk(irq_flag == 1'b1 || irq_cnt == 0, "R7 set wins", irq_flag, 1);
        @(negedge clk);
        chk(irq_flag == 1'b0, "R7 clear after set", irq_flag, 0);
        flag_clr = 1'b0;
        setup(VECS[1]);
        arm();
        edge_once();
        chk(wr_idx == 1, "R8 restart from source", wr_idx, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule